// File: doc/BRIEF.md
# Pixel Tile Sum and Absolute-Difference Accumulator

This block walks over one 16x16 tile of unsigned 8-bit pixels, delivered as a stream of 64-bit beats of eight pixels each, and produces a single 16-bit figure for the tile. In sum mode the figure is the total of all 256 current-block pixels. In SAD mode it is the sum of absolute differences between the current block and a reference block that arrives on a second beat input in lock-step. Two beats make up a row and sixteen rows make up the tile, so 32 beats complete it. Address generation and row stride belong to whatever feeds the block.

Each beat first passes through a per-byte stage. In SAD mode this stage forms the absolute difference as the OR of two saturating subtractions. In sum mode it passes the current pixels through unchanged. The resulting eight bytes are then widened into 16-bit half-word lanes. One copy of the beat is shifted right by eight inside every half-word, which yields the odd-position bytes. A second copy is masked with 0x00ff in every half-word, which yields the even-position bytes. The two copies are added per lane and accumulated in partitioned 16-bit registers, so no lane can wrap. Once the last beat of the tile has been taken, a separate reduction step adds the lane accumulators into the result.

A start pulse opens a tile, latches the mode and clears everything. Beats count only while the valid strobe is high. A one-cycle done pulse marks the result, and the result then stays on its output until the next start.

Top module: `pix_tile_sad`

## Requirements
- R1: After synchronous reset, `done_o` is 0 and `result_o` is 0. Both stay there while beats arrive before any start pulse.
- R2: With mode 0 (sum) latched, `result_o` equals the sum of all 256 bytes of the 32 accepted current beats. The reference beat input has no effect on it.
- R3: Accumulation never wraps. A sum-mode tile in which every byte is 255 gives exactly 65280.
- R4: With mode 1 (SAD) latched, `result_o` equals the sum over all 256 byte positions of |cur - ref|. Byte k of a beat is bits [8k+7:8k] of both inputs. Identical inputs give 0. Inputs of 255 against 0, in either order, give 65280.
- R5: A cycle with `valid_i` low contributes nothing. Idle gaps between beats do not change the result.
- R6: Let E be the clock edge that accepts the 32nd beat. `done_o` is high for exactly one cycle, starting at the edge after E. `result_o` carries the tile figure from that same edge.
- R7: `start_i` clears the beat count, the accumulators, `done_o` and `result_o` at its edge. A beat presented in the start cycle is dropped. A start in the middle of a tile abandons that tile.
- R8: After the done pulse, `result_o` holds its value and further valid beats are ignored. No second done pulse occurs until a new start.
- R9: `mode_i` is sampled only in the start cycle. Changing it during the tile has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new tile and clears all state |
| mode_i | input | 1 | 0 = pixel sum, 1 = absolute-difference sum; sampled with start_i |
| valid_i | input | 1 | Marks the beat inputs as carrying a beat this cycle |
| cur_beat_i | input | 64 | Eight current-block pixels, byte k in bits [8k+7:8k] |
| rfr_beat_i | input | 64 | Eight reference-block pixels, same byte order |
| result_o | output | 16 | Tile sum or tile SAD, held until the next start |
| done_o | output | 1 | One-cycle pulse when result_o becomes valid |

## Verification
A wrong internal state in this block shows up at the ports in only one place: the result and the done pulse at the end of a tile. A miscounted beat moves the done pulse by a cycle or suppresses it. A wrapped lane, a wrong widening mask or an absolute-difference slip changes the figure, and the corner tiles of all 255 or 255 against 0 make those errors large and certain. Neither kind of error is visible until the tile closes, so every tile is checked at the exact done cycle, one cycle before it and one cycle after it. Aborted tiles, dropped start-cycle beats and post-done beats are checked the same way, through the result of the tile that follows.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int PIX_W         = 8;
    localparam int HW_W          = 16;
    localparam int BEAT_PIX      = 8;
    localparam int BEAT_BITS     = BEAT_PIX * PIX_W;
    localparam int HW_LANES      = BEAT_BITS / HW_W;
    localparam int TILE_COLS     = 16;
    localparam int TILE_ROWS     = 16;
    localparam int BEATS_PER_ROW = TILE_COLS / BEAT_PIX;
    localparam int TILE_BEATS    = TILE_ROWS * BEATS_PER_ROW;
    localparam int CNT_W         = $clog2(TILE_BEATS + 1);

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic {
        PXS_SUM = 1'b0,
        PXS_SAD = 1'b1
    } pxs_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             fin;
    } pxs_seq_t;

    // Saturating subtraction: clamps at zero instead of wrapping.
    function automatic pix_t sat_sub(pix_t a, pix_t b);
        return (a > b) ? pix_t'(a - b) : '0;
    endfunction

endpackage

// File: rtl/pxs_absdiff.sv
module pxs_absdiff
    import pxs_pkg::*;
#(
    parameter int NPIX = BEAT_PIX
)(
    input  pxs_mode_e                mode_i,
    input  logic [NPIX*PIX_W-1:0]    cur_i,
    input  logic [NPIX*PIX_W-1:0]    rfr_i,
    output logic [NPIX*PIX_W-1:0]    beat_o
);

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pix_t c, r, d_cr, d_rc;

        assign c    = cur_i[p*PIX_W +: PIX_W];
        assign r    = rfr_i[p*PIX_W +: PIX_W];
        assign d_cr = sat_sub(c, r);
        assign d_rc = sat_sub(r, c);
        // One of the two clamped terms is always zero, so OR merges them.
        assign beat_o[p*PIX_W +: PIX_W] = (mode_i == PXS_SAD) ? (d_cr | d_rc) : c;

        always_comb begin
            if (mode_i == PXS_SAD) begin
                AST_ABS_MATCH: assert ((d_cr | d_rc) == ((c >= r) ? pix_t'(c - r) : pix_t'(r - c))); // R4
            end
        end
    end

endmodule

// File: rtl/pxs_widen.sv
module pxs_widen
    import pxs_pkg::*;
#(
    parameter int LANES = HW_LANES
)(
    input  logic [LANES*HW_W-1:0]        beat_i,
    output logic [LANES-1:0][HW_W-1:0]   pair_o
);

    localparam logic [HW_W-1:0] LOW_MASK = {{(HW_W-PIX_W){1'b0}}, {PIX_W{1'b1}}};

    for (genvar h = 0; h < LANES; h++) begin : g_hw
        logic [HW_W-1:0] hw, odd_w, even_w;

        assign hw     = beat_i[h*HW_W +: HW_W];
        assign odd_w  = hw >> PIX_W;
        assign even_w = hw & LOW_MASK;
        assign pair_o[h] = odd_w + even_w;
    end

endmodule

// File: rtl/pxs_lane_acc.sv
module pxs_lane_acc
    import pxs_pkg::*;
#(
    parameter int LANES = HW_LANES
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear_i,
    input  logic                         add_i,
    input  logic [LANES-1:0][HW_W-1:0]   inc_i,
    output logic [LANES-1:0][HW_W-1:0]   acc_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                acc_o[l] <= '0;
            end else if (add_i) begin
                acc_o[l] <= acc_o[l] + inc_i[l];
            end
        end

        AST_LANE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            (add_i && !clear_i) |=> (acc_o[l] >= $past(acc_o[l]))); // R3
    end

endmodule

// File: rtl/pxs_tile_seq.sv
module pxs_tile_seq
    import pxs_pkg::*;
#(
    parameter int BEATS = TILE_BEATS,
    localparam int CW   = $clog2(BEATS + 1)
)(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic valid_i,
    output logic accept_o,
    output logic fin_o
);

    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          fin_q;

    assign accept_o = active_q && valid_i && !start_i;
    assign fin_o    = fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            fin_q    <= 1'b0;
        end else if (start_i) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (accept_o) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end
            end
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_q == '0 && active_q && !fin_q)); // R7
    AST_FIN_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(BEATS)); // R6
    AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !accept_o); // R8

endmodule

// File: rtl/pix_tile_sad.sv
module pix_tile_sad
    import pxs_pkg::*;
#(
    parameter int LANES = HW_LANES,
    parameter int BEATS = TILE_BEATS,
    localparam int BW   = LANES * HW_W
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            mode_i,
    input  logic            valid_i,
    input  logic [BW-1:0]   cur_beat_i,
    input  logic [BW-1:0]   rfr_beat_i,
    output logic [HW_W-1:0] result_o,
    output logic            done_o
);

    pxs_mode_e                  mode_q;
    logic [BW-1:0]              byte_beat;
    logic [LANES-1:0][HW_W-1:0] pair_w;
    logic [LANES-1:0][HW_W-1:0] acc_w;
    logic                       accept_w;
    logic                       fin_w;
    logic [HW_W-1:0]            reduced;

    pxs_absdiff #(.NPIX(BW / PIX_W)) u_absdiff (
        .mode_i (mode_q),
        .cur_i  (cur_beat_i),
        .rfr_i  (rfr_beat_i),
        .beat_o (byte_beat)
    );

    pxs_widen #(.LANES(LANES)) u_widen (
        .beat_i (byte_beat),
        .pair_o (pair_w)
    );

    pxs_lane_acc #(.LANES(LANES)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_i),
        .add_i   (accept_w),
        .inc_i   (pair_w),
        .acc_o   (acc_w)
    );

    pxs_tile_seq #(.BEATS(BEATS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .valid_i  (valid_i),
        .accept_o (accept_w),
        .fin_o    (fin_w)
    );

    // Horizontal reduction across lanes, used only once per tile.
    always_comb begin
        reduced = '0;
        for (int i = 0; i < LANES; i++) begin
            reduced = reduced + acc_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= PXS_SUM;
            result_o <= '0;
            done_o   <= 1'b0;
        end else if (start_i) begin
            mode_q   <= pxs_mode_e'(mode_i);
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= fin_w;
            if (fin_w) begin
                result_o <= reduced;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6
    AST_DONE_FOLLOWS_FIN: assert property (@(posedge clk) disable iff (rst)
        (fin_w && !start_i) |=> done_o); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !fin_w) |=> $stable(result_o)); // R8
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (result_o == '0 && !done_o)); // R7

endmodule

// File: tb/tb_pix_tile_sad.sv
module tb_pix_tile_sad;

    localparam int NB = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, mode_i, valid_i;
    logic [63:0] cur_beat_i, rfr_beat_i;
    logic [15:0] result_o;
    logic        done_o;

    logic [63:0] cur_a [NB];
    logic [63:0] rfr_a [NB];
    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pix_tile_sad dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .valid_i(valid_i), .cur_beat_i(cur_beat_i), .rfr_beat_i(rfr_beat_i),
        .result_o(result_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic int tile_exp(input bit m);
        int s = 0;
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 8; k++) begin
                int c = int'(cur_a[b][k*8 +: 8]);
                int r = int'(rfr_a[b][k*8 +: 8]);
                if (m) s += (c > r) ? c - r : r - c;
                else   s += c;
            end
        end
        return s;
    endfunction

    // kind: 0 random, 1 cur 255 / ref 0, 2 cur 0 / ref 255, 3 equal random
    task automatic fill(input int kind);
        for (int b = 0; b < NB; b++) begin
            case (kind)
                1: begin cur_a[b] = '1; rfr_a[b] = '0; end
                2: begin cur_a[b] = '0; rfr_a[b] = '1; end
                3: begin cur_a[b] = rnd64(); rfr_a[b] = cur_a[b]; end
                default: begin cur_a[b] = rnd64(); rfr_a[b] = rnd64(); end
            endcase
        end
    endtask

    task automatic do_start(input bit m);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; valid_i = 1'b1;
        cur_beat_i = '1; rfr_beat_i = '0;        // dropped beat, R7
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0; mode_i = ~m;   // R9: later mode ignored
        chk(result_o == 16'd0 && done_o == 1'b0, "R7 start clears result", int'(result_o), 0);
    endtask

    task automatic send_beats(input int n, input bit gaps);
        for (int b = 0; b < n; b++) begin
            if (gaps) begin
                int k = int'($urandom_range(0, 2));
                for (int g = 0; g < k; g++) begin
                    valid_i = 1'b0; cur_beat_i = rnd64(); rfr_beat_i = rnd64();  // R5
                    @(negedge clk);
                end
            end
            valid_i = 1'b1; cur_beat_i = cur_a[b]; rfr_beat_i = rfr_a[b];
            @(negedge clk);
            valid_i = 1'b0;
        end
    endtask

    task automatic run_tile(input bit m, input bit gaps, input string tag);
        int exp;
        exp = tile_exp(m);
        do_start(m);
        send_beats(NB, gaps);
        chk(done_o == 1'b0, {tag, " R6 no early done"}, int'(done_o), 0);
        @(negedge clk);
        chk(done_o == 1'b1, {tag, " R6 done pulse"}, int'(done_o), 1);
        chk(int'(result_o) == exp, {tag, " result"}, int'(result_o), exp);
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R6 done one cycle"}, int'(done_o), 0);
        chk(int'(result_o) == exp, {tag, " R8 result held"}, int'(result_o), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; start_i = 1'b0; mode_i = 1'b0; valid_i = 1'b0;
        cur_beat_i = '0; rfr_beat_i = '0;
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0 && result_o == 16'd0, "R1 reset state", int'(result_o), 0);
        rst = 1'b0;

        // Beats before any start are ignored (R1)
        fill(1);
        send_beats(4, 1'b0);
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0 && result_o == 16'd0, "R1 no start no effect", int'(result_o), 0);

        fill(1); run_tile(1'b0, 1'b0, "R3 all-255 sum");
        fill(1); run_tile(1'b1, 1'b0, "R4 SAD 255 vs 0");
        fill(2); run_tile(1'b1, 1'b1, "R4 SAD 0 vs 255");
        fill(3); run_tile(1'b1, 1'b0, "R4 SAD equal");
        fill(2); run_tile(1'b0, 1'b0, "R2 sum ignores ref");

        for (int t = 0; t < 8; t++) begin
            fill(0);
            run_tile(t[0], 1'b1, "R2/R4/R5/R9 random tile");
        end

        // R8: beats after done ignored, no second done
        begin
            logic [15:0] held;
            held = result_o;
            fill(1);
            for (int b = 0; b < 6; b++) begin
                valid_i = 1'b1; cur_beat_i = cur_a[b]; rfr_beat_i = rfr_a[b];
                @(negedge clk);
                chk(done_o == 1'b0, "R8 no done after tile", int'(done_o), 0);
            end
            valid_i = 1'b0;
            repeat (2) @(negedge clk);
            chk(result_o == held, "R8 result unchanged", int'(result_o), int'(held));
        end

        // R7: mid-tile abort, then a full sum tile
        fill(1);
        do_start(1'b1);
        send_beats(10, 1'b0);
        fill(0);
        run_tile(1'b0, 1'b0, "R7 abort then sum");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule